// File: doc/BRIEF.md
# Key-Protected Random Word Generator

This peripheral hangs off a simple synchronous 32-bit register bus and delivers random 32-bit words to software. Generation is switched on and off through a control register that only listens when the upper 24 bits of the written value carry a fixed key pattern. A bad key, an accidental store or a runaway pointer therefore cannot start or stop the generator. Once running, an internal period timer produces a fresh word at a fixed interval, places it in the output data register and raises a data-ready flag in the status register.

Software polls the status register and then reads the output data. The status read itself clears data-ready, so a word that was already fetched is never reported as fresh a second time. A mode bit doubles the generation interval for use with fast system clocks. The entropy source here is a deterministic 32-bit Galois LFSR, which makes the word sequence predictable for verification.

Top module: `keyed_rng_periph`

## Requirements
- R1: Register map by byte offset. 0x00 is control, 0x04 is mode, 0x1C is status and 0x50 is output data. Control and unmapped offsets read as zero. Mode reads back its bit 0. Status bit 0 is data-ready. Output data returns the latest word.
- R2: A write to control changes the enable only when wdata[31:8] equals 0x524E47. If it does, wdata[0] becomes the enable. A write with any other key leaves the enable unchanged, whatever the value of bit 0.
- R3: In full-rate mode (mode bit 0 = 0), a new word is produced every 84 clock cycles. The period counter restarts on every disabled-to-enabled transition. The first word is loaded on the 84th rising edge after the edge that accepted the enable.
- R4: In half-rate mode (mode bit 0 = 1), the interval is 168 clock cycles. The first word is loaded on the 168th edge after enabling.
- R5: Data-ready is set on the edge that loads a new word. A status read clears it on the following edge. If a status read and a new word fall on the same edge, the flag is set.
- R6: While disabled, no word is produced, the output data holds its value and data-ready is never set.
- R7: Words follow a right-shifting Galois LFSR with tap mask 0xB4BCD35C and seed 0xACE12468. Each produced word is the next state, so the first word is next(seed). The state advances only when a word is produced and is never zero.
- R8: Writes to the status and output data offsets have no effect.
- R9: Reset clears the enable, the half-rate bit, data-ready and the output data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid combinationally while bus_rd_en is high |

## Verification
The assertions assume that a bus access lasts exactly one cycle. The address is taken as stable while a strobe is high, and read and write strobes are never raised in the same cycle. The timing properties also assume that the mode bit is changed only while the generator is disabled, because they relate the period counter to the mode sampled on the same cycle. The stimulus keeps to these limits. It issues one access per strobe cycle and never combines a read with a write. It changes the half-rate bit only after disabling, and it times each status poll against the cycle on which the enable was accepted.

// File: rtl/rng_pkg.sv
package rng_pkg;
   localparam int unsigned OFFS_W = 8;
   localparam logic [OFFS_W-1:0] OFFS_CTRL   = 8'h00;
   localparam logic [OFFS_W-1:0] OFFS_MODE   = 8'h04;
   localparam logic [OFFS_W-1:0] OFFS_STATUS = 8'h1C;
   localparam logic [OFFS_W-1:0] OFFS_DATA   = 8'h50;

   localparam logic [23:0] UNLOCK_KEY = 24'h524E47;

   typedef struct packed {
      logic gen_en;
      logic half_rate;
   } rng_cfg_t;
endpackage

// File: rtl/rng_key_ctrl.sv
module rng_key_ctrl
   import rng_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-9:0] KEY = UNLOCK_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output rng_cfg_t          cfg
);
   localparam int unsigned KEY_W = DATA_W - 8;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFFS_CTRL);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFFS_MODE);

   initial begin
      assert (DATA_W >= 16) else $error("DATA_W too small for key field");
      assert (ADDR_W >= 7)  else $error("ADDR_W cannot reach all offsets");
   end

   logic ctrl_hit, key_ok, mode_hit;
   logic unused_wdata_bits;

   assign ctrl_hit = wr_en && (addr == A_CTRL);
   assign mode_hit = wr_en && (addr == A_MODE);
   assign key_ok   = (wdata[DATA_W-1 -: KEY_W] == KEY);
   assign unused_wdata_bits = ^wdata[7:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else begin
         if (ctrl_hit && key_ok) cfg.gen_en <= wdata[0];
         if (mode_hit)           cfg.half_rate <= wdata[0];
      end
   end

   // R2: a control write with a wrong key leaves the enable untouched
   assert_bad_key_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && !key_ok) |=> $stable(cfg.gen_en));
   // R2: an accepted write takes bit 0 as the enable
   assert_key_write_applied_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_hit && key_ok) |=> (cfg.gen_en == $past(wdata[0])));
endmodule

// File: rtl/rng_period_timer.sv
module rng_period_timer #(
   parameter int unsigned FULL_PERIOD = 84,
   parameter int unsigned SLOW_FACTOR = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slow,
   output logic tick
);
   localparam int unsigned SLOW_PERIOD = FULL_PERIOD * SLOW_FACTOR;
   localparam int unsigned CNT_W = $clog2(SLOW_PERIOD);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_PERIOD - 1);
   localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_PERIOD - 1);

   initial begin
      assert (FULL_PERIOD >= 2) else $error("FULL_PERIOD must be at least 2");
      assert (SLOW_FACTOR >= 1) else $error("SLOW_FACTOR must be at least 1");
   end

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] last_val;

   assign last_val = slow ? SLOW_LAST : FULL_LAST;
   assign tick     = run && (count_q >= last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_q <= '0;
      else if (!run)   count_q <= '0;
      else if (tick)   count_q <= '0;
      else             count_q <= count_q + 1'b1;
   end

   // R3: the counter never passes the longest interval
   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= SLOW_LAST);
   // R3: a word boundary restarts the interval
   assert_restart_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (count_q == '0));
   // R4: in half-rate mode a tick needs the full slow interval
   assert_slow_interval_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && slow) |-> (count_q == SLOW_LAST));
endmodule

// File: rtl/rng_lfsr_source.sv
module rng_lfsr_source #(
   parameter int unsigned WIDTH = 32,
   parameter logic [WIDTH-1:0] TAPS = 32'hB4BC_D35C,
   parameter logic [WIDTH-1:0] SEED = 32'hACE1_2468
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [WIDTH-1:0] next_word
);
   initial begin
      assert (SEED != '0) else $error("LFSR seed must be non-zero");
      assert (TAPS[WIDTH-1]) else $error("tap mask must include the top bit");
   end

   logic [WIDTH-1:0] state_q;

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         if (b == WIDTH - 1) begin : g_top
            assign next_word[b] = TAPS[b] & state_q[0];
         end else begin : g_mid
            assign next_word[b] = state_q[b+1] ^ (TAPS[b] & state_q[0]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state_q <= SEED;
      else if (step) state_q <= next_word;
   end

   // R7: the source never locks up in the all-zero state
   assert_state_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);
   // R7: the state only moves when a word is taken
   assert_hold_without_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(state_q));
endmodule

// File: rtl/keyed_rng_periph.sv
module keyed_rng_periph
   import rng_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned FULL_PERIOD = 84,
   parameter int unsigned SLOW_FACTOR = 2,
   parameter logic [31:0] LFSR_TAPS   = 32'hB4BC_D35C,
   parameter logic [31:0] LFSR_SEED   = 32'hACE1_2468
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd_en,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFFS_MODE);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFFS_STATUS);
   localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFFS_DATA);

   initial begin
      assert (DATA_W == 32) else $error("tap and seed parameters assume 32 bits");
   end

   rng_cfg_t          cfg;
   logic              word_tick;
   logic [DATA_W-1:0] fresh_word;
   logic [DATA_W-1:0] out_word_q;
   logic              ready_q;
   logic              status_rd;

   rng_key_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_wr_en),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .cfg   (cfg)
   );

   rng_period_timer #(.FULL_PERIOD(FULL_PERIOD), .SLOW_FACTOR(SLOW_FACTOR)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (cfg.gen_en),
      .slow  (cfg.half_rate),
      .tick  (word_tick)
   );

   rng_lfsr_source #(.WIDTH(DATA_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (word_tick),
      .next_word (fresh_word)
   );

   assign status_rd = bus_rd_en && (bus_addr == A_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_word_q <= '0;
         ready_q    <= 1'b0;
      end else begin
         if (word_tick) out_word_q <= fresh_word;
         if (word_tick)      ready_q <= 1'b1;
         else if (status_rd) ready_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd_en) begin
         unique case (bus_addr)
            A_MODE:   bus_rdata = DATA_W'(cfg.half_rate);
            A_STATUS: bus_rdata = DATA_W'(ready_q);
            A_DATA:   bus_rdata = out_word_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   // R5: the flag only rises together with a newly loaded word
   assert_ready_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> $past(word_tick));
   // R5: a status read without a new word leaves the flag low
   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !word_tick) |=> !ready_q);
   // R6: a disabled generator keeps the flag low and the word fixed
   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.gen_en && !ready_q) |=> (!ready_q && $stable(out_word_q)));
endmodule

// File: tb/keyed_rng_periph_tb_top.sv
module keyed_rng_periph_tb_top;
   localparam logic [31:0] TAPS = 32'hB4BC_D35C;
   localparam logic [31:0] SEED = 32'hACE1_2468;
   localparam logic [31:0] KEY_ON  = 32'h524E_4701;
   localparam logic [31:0] KEY_OFF = 32'h524E_4700;

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   // register-map walk straight after reset (R1, R9)
   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h00, 32'h0, 32'h0, 4'd9},
      '{1'b0, 8'h04, 32'h0, 32'h0, 4'd9},
      '{1'b0, 8'h1C, 32'h0, 32'h0, 4'd9},
      '{1'b0, 8'h50, 32'h0, 32'h0, 4'd9},
      '{1'b0, 8'h08, 32'h0, 32'h0, 4'd1},
      '{1'b0, 8'h60, 32'h0, 32'h0, 4'd1},
      '{1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0, 4'd1},
      '{1'b0, 8'h04, 32'h0, 32'h1, 4'd1},
      '{1'b1, 8'h04, 32'h0, 32'h0, 4'd1},
      '{1'b0, 8'h04, 32'h0, 32'h0, 4'd1},
      '{1'b0, 8'h00, 32'h0, 32'h0, 4'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd_en = 1'b0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   logic [31:0] model;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   keyed_rng_periph dut_i (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr_en (bus_wr_en),
      .bus_wdata (bus_wdata), .bus_rd_en (bus_rd_en), .bus_rdata (bus_rdata)
   );

   function automatic logic [31:0] lfsr_next(input logic [31:0] s);
      return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd_en = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   task automatic wait_to(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   initial begin
      logic [31:0] rd;
      int e;
      model = SEED;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
         else begin
            bus_read(VECS[i].addr, rd);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
         end
      end

      // R2: wrong key with bit 0 set does not start the generator
      bus_write(8'h00, 32'h1234_5601);
      e = cyc;
      wait_to(e + 100);
      bus_read(8'h1C, rd); check("R2 bad key no start", rd, 32'h0);

      // R3: full-rate words at 84 and 168 cycles, R5 set wins over read, R7 words
      bus_write(8'h00, KEY_ON);
      e = cyc;
      wait_to(e + 83);
      bus_read(8'h1C, rd); check("R3 not yet ready", rd, 32'h0);
      bus_read(8'h1C, rd); check("R5 set wins over clear", rd, 32'h1);
      bus_read(8'h50, rd); model = lfsr_next(model); check("R7 first word", rd, model);
      bus_read(8'h1C, rd); check("R5 read clears flag", rd, 32'h0);
      wait_to(e + 167);
      bus_read(8'h1C, rd); check("R3 second word not early", rd, 32'h0);
      bus_read(8'h1C, rd); check("R3 second word ready", rd, 32'h1);
      bus_read(8'h50, rd); model = lfsr_next(model); check("R7 second word", rd, model);

      // R2: wrong key with bit 0 clear does not stop the generator
      bus_write(8'h00, 32'hDEAD_BE00);
      wait_to(e + 252);
      bus_read(8'h1C, rd); check("R2 bad key no stop", rd, 32'h1);
      bus_read(8'h50, rd); model = lfsr_next(model); check("R7 third word", rd, model);

      // R6: disable, then R8 writes to read-only offsets
      bus_write(8'h00, KEY_OFF);
      e = cyc;
      wait_to(e + 200);
      bus_read(8'h1C, rd); check("R6 no ready while off", rd, 32'h0);
      bus_write(8'h1C, 32'h1);
      bus_write(8'h50, 32'hFFFF_FFFF);
      bus_read(8'h1C, rd); check("R8 status write ignored", rd, 32'h0);
      bus_read(8'h50, rd); check("R8 data write ignored", rd, model);

      // R3: re-enabling restarts the interval
      bus_write(8'h00, KEY_ON);
      e = cyc;
      wait_to(e + 40);
      bus_write(8'h00, KEY_OFF);
      bus_write(8'h00, KEY_ON);
      e = cyc;
      wait_to(e + 83);
      bus_read(8'h1C, rd); check("R3 restart not early", rd, 32'h0);
      bus_read(8'h1C, rd); check("R3 restart word ready", rd, 32'h1);
      bus_read(8'h50, rd); model = lfsr_next(model); check("R7 fourth word", rd, model);

      // R4: half-rate interval
      bus_write(8'h00, KEY_OFF);
      bus_write(8'h04, 32'h1);
      bus_read(8'h04, rd); check("R1 mode readback", rd, 32'h1);
      bus_write(8'h00, KEY_ON);
      e = cyc;
      wait_to(e + 84);
      bus_read(8'h1C, rd); check("R4 no word at 84", rd, 32'h0);
      wait_to(e + 167);
      bus_read(8'h1C, rd); check("R4 not early", rd, 32'h0);
      bus_read(8'h1C, rd); check("R4 word at 168", rd, 32'h1);
      bus_read(8'h50, rd); model = lfsr_next(model); check("R7 fifth word", rd, model);
      bus_read(8'h00, rd); check("R1 control reads zero", rd, 32'h0);

      // R9: reset clears mode and flags again
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(8'h04, rd); check("R9 mode cleared", rd, 32'h0);
      bus_read(8'h50, rd); check("R9 data cleared", rd, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule